// File: doc/BRIEF.md
# UART Command to SPI DAC Writer

This block sits behind a UART byte receiver and turns ASCII text lines into writes to a 16-bit SPI digital-to-analog converter. Each received byte arrives with a one-cycle valid strobe. The block gathers characters into a line of bounded length. A line that holds only decimal digits and ends with a line feed is read as a DAC code. The code is then shifted out as two bytes, high byte first, inside a single chip-select window.

Lines that are too long raise an overflow pulse, and the rest of the line is thrown away. Lines with a value out of range, a stray character or no characters at all are dropped without a write. Codes that are accepted while a transfer is still running wait in a small in-order queue. A busy output shows when a frame is being sent or is waiting to be sent. The serial clock rate, the line length, the code width and the queue depth are all parameters.

Top module: `dac_cmd_writer`

## Requirements
- R1: While reset is high, and after it is released with no input, `spi_cs_n` is 1 and `spi_sclk`, `spi_mosi`, `busy` and `overflow` are 0.
- R2: A line made of 1 to 16 decimal digits ('0'..'9', 0x30..0x39) followed by a line feed (0x0A) produces one frame. In that frame `spi_cs_n` goes low, `spi_sclk` rises exactly 16 times, and `spi_cs_n` then goes high again. The 16 bits sampled on the rising edges are the decimal value, high byte first and most significant bit first.
- R3: The serial port runs in mode 0. `spi_sclk` is low whenever `spi_cs_n` is high, and `spi_mosi` does not change while `spi_sclk` is high.
- R4: The line buffer holds 16 characters. A line of exactly 16 digits before the line feed is accepted, and leading zeros are allowed.
- R5: When a 17th character that is not a line feed arrives, `overflow` is 1 for exactly the one cycle after that byte is taken. The line is discarded, and every byte up to and including the next line feed is ignored. The line after that is handled normally.
- R6: A line whose decimal value is greater than 65535 causes no frame.
- R7: An empty line (a line feed alone), or a line that contains any byte other than a digit, causes no frame.
- R8: Lines accepted while a frame is in progress are queued, up to 4 of them. They are sent in the order they arrived.
- R9: Between two frames, `spi_cs_n` stays high for at least one full serial clock period (2 × `SCLK_HALF` clock cycles).
- R10: `busy` is 1 whenever `spi_cs_n` is low. It rises within two cycles after the line feed of an accepted line is taken, and it stays 0 after a rejected line when nothing else is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 8 | Received byte from the UART |
| rx_valid | input | 1 | One-cycle strobe qualifying `rx_data` |
| spi_sclk | output | 1 | Serial clock to the DAC, idles low |
| spi_mosi | output | 1 | Serial data to the DAC |
| spi_cs_n | output | 1 | Active-low chip select to the DAC |
| busy | output | 1 | A frame is being sent or is queued |
| overflow | output | 1 | One-cycle pulse when a line exceeds the buffer |

## Verification
The properties assume a few things about the inputs. Each byte is presented as a single-cycle `rx_valid` strobe. Reset is held for several cycles. The source never has more accepted lines outstanding than the queue can hold, because a full queue drops the newest code. The stimulus meets these conditions: it spaces bytes with an idle cycle, waits for `busy` to fall between most commands, and sends only three lines in a row for the ordering test, which is below the queue depth.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;

    localparam logic [7:0] ASCII_LF   = 8'h0A;
    localparam logic [7:0] ASCII_ZERO = 8'h30;
    localparam logic [7:0] ASCII_NINE = 8'h39;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_SHIFT,
        TX_TAIL,
        TX_GAP
    } tx_state_t;

    // Per-line condition bits collected while characters arrive
    typedef struct packed {
        logic drop;   // line exceeded the buffer, discard until line feed
        logic bad;    // a non-digit character was seen
        logic big;    // value went past the code range
    } line_flags_t;

    function automatic logic is_digit(input logic [7:0] c);
        return (c >= ASCII_ZERO) && (c <= ASCII_NINE);
    endfunction

    function automatic logic [3:0] digit_val(input logic [7:0] c);
        logic [7:0] d;
        d = c - ASCII_ZERO;
        return d[3:0];
    endfunction

endpackage

// File: rtl/dac_line_parser.sv
module dac_line_parser
    import dac_cmd_pkg::*;
#(
    parameter int CODE_W   = 16,
    parameter int LINE_LEN = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        rx_data,
    input  logic              rx_valid,
    output logic              push_o,
    output logic [CODE_W-1:0] code_o,
    output logic              ovf_o
);

    localparam int CNT_W = $clog2(LINE_LEN + 1);
    localparam int ACC_W = CODE_W + 4;
    localparam logic [ACC_W-1:0] CODE_MAX = {4'b0000, {CODE_W{1'b1}}};

    logic [CNT_W-1:0]  cnt;
    logic [CODE_W-1:0] acc;
    line_flags_t       flags;
    logic [ACC_W-1:0]  prod;
    logic              is_lf;
    logic              full;

    always_comb begin
        prod  = ({4'b0000, acc} << 3) + ({4'b0000, acc} << 1)
              + ACC_W'(digit_val(rx_data));
        is_lf = (rx_data == ASCII_LF);
        full  = (cnt == CNT_W'(LINE_LEN));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            acc    <= '0;
            flags  <= '0;
            push_o <= 1'b0;
            code_o <= '0;
            ovf_o  <= 1'b0;
        end else begin
            push_o <= 1'b0;
            ovf_o  <= 1'b0;
            if (rx_valid) begin
                if (flags.drop) begin
                    if (is_lf) begin
                        cnt   <= '0;
                        acc   <= '0;
                        flags <= '0;
                    end
                end else if (is_lf) begin
                    push_o <= (cnt != '0) && !flags.bad && !flags.big;
                    code_o <= acc;
                    cnt    <= '0;
                    acc    <= '0;
                    flags  <= '0;
                end else if (full) begin
                    ovf_o      <= 1'b1;
                    flags.drop <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                    if (!is_digit(rx_data)) begin
                        flags.bad <= 1'b1;
                    end else if (prod > CODE_MAX) begin
                        flags.big <= 1'b1;
                    end else if (!flags.big) begin
                        acc <= prod[CODE_W-1:0];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/dac_code_fifo.sv
module dac_code_fifo #(
    parameter int CODE_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [CODE_W-1:0] wdata,
    input  logic              pop,
    output logic [CODE_W-1:0] rdata,
    output logic              empty
);

    localparam int AW = $clog2(DEPTH);

    logic [CODE_W-1:0] mem [DEPTH];
    logic [AW:0]       wptr;
    logic [AW:0]       rptr;
    logic              full;

    always_comb begin
        empty = (wptr == rptr);
        full  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
        rdata = mem[rptr[AW-1:0]];
    end

    always_ff @(posedge clk) begin
        if (push && !full) begin
            mem[wptr[AW-1:0]] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (push && !full) wptr <= wptr + 1'b1;
            if (pop && !empty) rptr <= rptr + 1'b1;
        end
    end

endmodule

// File: rtl/dac_spi_tx.sv
module dac_spi_tx
    import dac_cmd_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int HALF   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WORD_W-1:0] data,
    output logic              ready,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n
);

    localparam int TW = $clog2(2 * HALF + 1);
    localparam int BW = $clog2(WORD_W);
    localparam logic [TW-1:0] HALF_LAST = TW'(HALF - 1);
    localparam logic [TW-1:0] GAP_LAST  = TW'(2 * HALF - 1);
    localparam logic [BW-1:0] BIT_LAST  = BW'(WORD_W - 1);

    tx_state_t         state;
    logic [WORD_W-1:0] shreg;
    logic [BW-1:0]     bitcnt;
    logic [TW-1:0]     tcnt;

    always_comb begin
        ready = (state == TX_IDLE);
        mosi  = !cs_n && shreg[WORD_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= TX_IDLE;
            shreg  <= '0;
            bitcnt <= '0;
            tcnt   <= '0;
            sclk   <= 1'b0;
            cs_n   <= 1'b1;
        end else begin
            case (state)
                TX_IDLE: begin
                    if (start) begin
                        shreg  <= data;
                        bitcnt <= '0;
                        tcnt   <= '0;
                        cs_n   <= 1'b0;
                        state  <= TX_SHIFT;
                    end
                end
                TX_SHIFT: begin
                    if (tcnt == HALF_LAST) begin
                        tcnt <= '0;
                        if (!sclk) begin
                            sclk <= 1'b1;
                        end else begin
                            sclk <= 1'b0;
                            if (bitcnt == BIT_LAST) begin
                                state <= TX_TAIL;
                            end else begin
                                bitcnt <= bitcnt + 1'b1;
                                shreg  <= shreg << 1;
                            end
                        end
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                TX_TAIL: begin
                    if (tcnt == HALF_LAST) begin
                        tcnt  <= '0;
                        cs_n  <= 1'b1;
                        state <= TX_GAP;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                TX_GAP: begin
                    if (tcnt == GAP_LAST) begin
                        tcnt  <= '0;
                        state <= TX_IDLE;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dac_cmd_writer.sv
module dac_cmd_writer #(
    parameter int CODE_W      = 16,
    parameter int LINE_LEN    = 16,
    parameter int QUEUE_DEPTH = 4,
    parameter int SCLK_HALF   = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] rx_data,
    input  logic       rx_valid,
    output logic       spi_sclk,
    output logic       spi_mosi,
    output logic       spi_cs_n,
    output logic       busy,
    output logic       overflow
);

    logic              line_push;
    logic [CODE_W-1:0] line_code;
    logic [CODE_W-1:0] q_code;
    logic              q_empty;
    logic              tx_ready;
    logic              tx_start;

    dac_line_parser #(
        .CODE_W   (CODE_W),
        .LINE_LEN (LINE_LEN)
    ) u_parser (
        .clk      (clk),
        .rst      (rst),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .push_o   (line_push),
        .code_o   (line_code),
        .ovf_o    (overflow)
    );

    dac_code_fifo #(
        .CODE_W (CODE_W),
        .DEPTH  (QUEUE_DEPTH)
    ) u_queue (
        .clk   (clk),
        .rst   (rst),
        .push  (line_push),
        .wdata (line_code),
        .pop   (tx_start),
        .rdata (q_code),
        .empty (q_empty)
    );

    assign tx_start = tx_ready && !q_empty;

    dac_spi_tx #(
        .WORD_W (CODE_W),
        .HALF   (SCLK_HALF)
    ) u_tx (
        .clk   (clk),
        .rst   (rst),
        .start (tx_start),
        .data  (q_code),
        .ready (tx_ready),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi),
        .cs_n  (spi_cs_n)
    );

    assign busy = !q_empty || !tx_ready;

endmodule

// File: rtl/dac_cmd_writer_chk.sv
module dac_cmd_writer_chk #(
    parameter int FRAME_BITS = 16,
    parameter int HALF       = 2
) (
    input logic clk,
    input logic rst,
    input logic spi_sclk,
    input logic spi_mosi,
    input logic spi_cs_n,
    input logic busy,
    input logic overflow
);

    localparam int EW = $clog2(FRAME_BITS + 2);
    localparam int GW = $clog2(2 * HALF + 1);
    localparam logic [GW-1:0] GAP_MIN = GW'(2 * HALF);

    logic          sclk_q;
    logic [EW-1:0] edge_cnt;
    logic [GW-1:0] gap_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q   <= 1'b0;
            edge_cnt <= '0;
            gap_cnt  <= GAP_MIN;
        end else begin
            sclk_q <= spi_sclk;
            if (spi_cs_n) begin
                edge_cnt <= '0;
                if (gap_cnt < GAP_MIN) gap_cnt <= gap_cnt + 1'b1;
            end else begin
                gap_cnt <= '0;
                if (spi_sclk && !sclk_q) edge_cnt <= edge_cnt + 1'b1;
            end
        end
    end

    p_frame_len_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_cs_n) |-> (edge_cnt == EW'(FRAME_BITS)));

    p_sclk_idle_r3: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk);

    p_mosi_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    p_ovf_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        overflow |=> !overflow);

    p_cs_gap_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_cs_n) |-> (gap_cnt >= GAP_MIN));

    p_busy_frame_r10: assert property (@(posedge clk) disable iff (rst)
        !spi_cs_n |-> busy);

endmodule

bind dac_cmd_writer dac_cmd_writer_chk #(
    .FRAME_BITS (CODE_W),
    .HALF       (SCLK_HALF)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .spi_sclk (spi_sclk),
    .spi_mosi (spi_mosi),
    .spi_cs_n (spi_cs_n),
    .busy     (busy),
    .overflow (overflow)
);

// File: tb/dac_cmd_writer_bench.sv
module dac_cmd_writer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       spi_sclk;
    logic       spi_mosi;
    logic       spi_cs_n;
    logic       busy;
    logic       overflow;

    int tests = 0;
    int fails = 0;
    int exp_q[$];
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dac_cmd_writer #(
        .CODE_W      (16),
        .LINE_LEN    (16),
        .QUEUE_DEPTH (4),
        .SCLK_HALF   (HALF)
    ) u_dac_cmd_writer (
        .clk      (clk),
        .rst      (rst),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .spi_sclk (spi_sclk),
        .spi_mosi (spi_mosi),
        .spi_cs_n (spi_cs_n),
        .busy     (busy),
        .overflow (overflow)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural observer of the serial port, evaluated every clock
    bit        prev_cs   = 1'b1;
    bit        prev_sclk = 1'b0;
    bit        prev_mosi = 1'b0;
    int        nbits     = 0;
    int        gap       = 100;
    bit [15:0] word      = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (prev_cs && !spi_cs_n) begin
                check(gap >= 2 * HALF, "R9", "cs high gap", gap, 2 * HALF);
                if (exp_q.size() == 0)
                    check(1'b0, "R6/R7", "unexpected frame", 1, 0);
                nbits = 0;
                word  = '0;
            end
            if (!spi_cs_n && spi_sclk && !prev_sclk) begin
                word  = {word[14:0], spi_mosi};
                nbits = nbits + 1;
            end
            if (!prev_cs && spi_cs_n) begin
                check(nbits == 16, "R2", "rising edges per frame", nbits, 16);
                if (exp_q.size() > 0) begin
                    check(word == exp_q[0], "R2/R8", "frame word", word, exp_q[0]);
                    void'(exp_q.pop_front());
                end
            end
            if (spi_cs_n) begin
                if (gap < 100) gap = gap + 1;
                check(!spi_sclk, "R3", "sclk while deselected", spi_sclk, 0);
            end else begin
                gap = 0;
                check(busy, "R10", "busy during frame", busy, 1);
            end
            if (spi_sclk && prev_sclk)
                check(spi_mosi == prev_mosi, "R3", "mosi while sclk high", spi_mosi, prev_mosi);
            prev_cs   = spi_cs_n;
            prev_sclk = spi_sclk;
            prev_mosi = spi_mosi;
        end
    end

    task automatic send_byte(input logic [7:0] c, input bit exp_ovf);
        @(negedge clk);
        rx_data  = c;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        check(overflow == exp_ovf, "R5", "overflow pulse", overflow, exp_ovf);
    endtask

    task automatic send_line(input string s);
        bit     ok;
        bit     accept;
        bit     idle_before;
        longint val;
        int     len;
        len         = s.len();
        ok          = 1'b1;
        val         = 0;
        idle_before = !busy && (exp_q.size() == 0);
        for (int i = 0; i < len; i++) begin
            if (s[i] < "0" || s[i] > "9") ok = 1'b0;
            else if (val <= 100000) val = val * 10 + (s[i] - "0");
        end
        accept = (len > 0) && (len <= 16) && ok && (val <= 65535);
        for (int i = 0; i < len; i++) send_byte(s[i], i == 16);
        if (accept) exp_q.push_back(int'(val));
        send_byte(8'h0A, 1'b0);
        @(negedge clk);
        @(negedge clk);
        if (accept)
            check(busy == 1'b1, "R10", "busy after accepted line", busy, 1);
        else if (idle_before)
            check(busy == 1'b0, "R6/R7", "busy after rejected line", busy, 0);
    endtask

    task automatic wait_idle();
        while (busy || exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R8", "pending frames", exp_q.size(), 0);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R8 watchdog: actual=%0d expected=%0d", 0, 1);
            finish_run();
        end
    end

    initial begin
        rst      = 1'b1;
        rx_data  = 8'h00;
        rx_valid = 1'b0;
        repeat (4) @(negedge clk);
        // R1: state during reset
        check(spi_cs_n == 1'b1, "R1", "cs_n in reset", spi_cs_n, 1);
        check(spi_sclk == 1'b0, "R1", "sclk in reset", spi_sclk, 0);
        check(busy == 1'b0 && overflow == 1'b0, "R1", "busy/overflow in reset",
              {busy, overflow}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(spi_cs_n == 1'b1 && spi_mosi == 1'b0, "R1", "cs_n/mosi after reset",
              {spi_cs_n, spi_mosi}, 2);
        check(busy == 1'b0, "R1", "busy after reset", busy, 0);

        // R2: basic codes, checked bit-exact by the observer
        send_line("0");        wait_idle();
        send_line("65535");    wait_idle();
        send_line("43981");    wait_idle();
        send_line("4660");     wait_idle();

        // R4: full-length line with leading zeros
        send_line("0000000000065535"); wait_idle();
        send_line("0000000000000258"); wait_idle();

        // R5: seventeen characters then recovery
        send_line("00000000000000001");      wait_idle();
        send_line("1234567890123456789012"); wait_idle();
        send_line("21845");                  wait_idle();

        // R6: out-of-range values
        send_line("65536");    wait_idle();
        send_line("99999999"); wait_idle();

        // R7: empty line and foreign characters
        send_line("");         wait_idle();
        send_line("12a4");     wait_idle();
        send_line(" 7");       wait_idle();

        // R8: back-to-back lines are queued and kept in order
        send_line("1");
        send_line("32768");
        send_line("255");
        wait_idle();

        check(busy == 1'b0 && spi_cs_n == 1'b1, "R10", "idle at end",
              {busy, spi_cs_n}, 1);
        done = 1'b1;
        finish_run();
    end

endmodule